// File: doc/BRIEF.md
# Power-Management Event Controller

This block gathers platform wake and attention events into a small register file and turns them into one level-sensitive system-control interrupt line. Pulses from a power button, a real-time-clock alarm and a global-lock release each latch a status bit. A free-running tick counter latches a fourth status bit when its most significant bit flips. Each status bit has a matching enable bit. The interrupt is asserted while any enabled status bit among those four sources is set. Software acknowledges an event by writing a one to its status bit.

The register file sits in a 64-byte I/O window on a simple host register bus. Two configuration writes place and open the window. The first carries a 32-bit base value whose low six bits are dropped. The second carries a control byte whose bit 0 opens the window. The window is closed after reset. The timer advances on a one-cycle tick strobe supplied by the surrounding clocking logic, so the whole block runs on one clock. The register bus is a plain strobe interface with no back-pressure: a write completes in the cycle it is presented, and a read returns its data on the following cycle.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, all of the following are zero: status, enable, control, the timer count, the read-data output and the interrupt. The window is closed and the base is zero.
- R2: A configuration write with `cfg_sel`=0 loads the window base from `cfg_wdata` masked with 0xFFC0. A write with `cfg_sel`=1 opens the window when `cfg_wdata[0]`=1 and closes it otherwise. A bus access hits only while the window is open and `bus_addr[15:6]` equals the base bits 15:6. A write that misses changes nothing, and a read that misses returns 0.
- R3: Byte offsets inside the window select registers as follows: 0x00 status, 0x02 enable, 0x04 control, 0x08 timer bits 15:0, 0x0A timer bits above 15, zero-extended. Every other offset, odd offsets included, reads 0 and ignores writes. Read data appears on `bus_rdata` one clock after `bus_rd` and holds until the next read.
- R4: Status bit positions are: 0 timer, 5 global lock, 8 power button, 10 RTC. A one-cycle pulse on `ev_pwrbtn`, `ev_glock` or `ev_rtc` sets its status bit at the next clock edge, whatever the enable bit holds. Status bits at all other positions always read 0.
- R5: Writing status clears each bit written as 1 and leaves each bit written as 0. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: The enable and control registers are 16 bits wide, and every bit can be written and read back.
- R7: The timer is a TMR_W-bit counter. It advances by one on each clock that has `tmr_tick` high, and it wraps to zero.
- R8: When a tick makes the counter's top bit flip, the timer status bit is set, but only if timer enable (enable bit 0) is 1 and timer status is 0 in that cycle. With timer enable 0, a flip leaves the timer status bit unchanged.
- R9: `sci_out` is a register. One clock after the status or enable register changes, it equals the OR over bits 0, 5, 8 and 10 of (status AND enable). No other bit position affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: window base value, 1: window control byte |
| cfg_wdata | input | 32 | Configuration write data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data, valid one clock after `bus_rd` |
| tmr_tick | input | 1 | Timer advance strobe |
| ev_pwrbtn | input | 1 | Power-button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| ev_glock | input | 1 | Global-lock release event pulse |
| sci_out | output | 1 | Level-sensitive system-control interrupt |

## Verification
The bench builds the block with TMR_W=8 and the default ADDR_W=16. With an 8-bit counter the top bit flips every 128 ticks, so both the rising flip and the flip at wrap-around happen within a few hundred cycles. That brings the armed and disarmed cases of the timer event, and the wrap of the counter, into a short run. A 16-bit address lets random accesses land inside, beside and far from a window that the bench moves during the run.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  localparam int REG_W = 16;

  // status / enable bit positions
  localparam int BIT_TMR = 0;
  localparam int BIT_GLK = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GLK) | (1 << BIT_PWR) | (1 << BIT_RTC));

  // byte offsets inside the window
  localparam int OFS_STATUS  = 0;
  localparam int OFS_ENABLE  = 2;
  localparam int OFS_CONTROL = 4;
  localparam int OFS_TMR_LO  = 8;
  localparam int OFS_TMR_HI  = 10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CONTROL,
    SEL_TMR_LO,
    SEL_TMR_HI
  } reg_sel_e;
endpackage

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] count,
  output logic             msb_flip
);
  // the top bit flips exactly when a tick arrives with all lower bits set
  assign msb_flip = tick & (&count[TMR_W-2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/pm_win_decode.sv
`timescale 1ns/1ps
module pm_win_decode import pm_pkg::*; #(
  parameter int ADDR_W  = 16,
  parameter int WIN_LG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              win_en,
  output logic              hit,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:WIN_LG2] base_q;
  logic [WIN_LG2-1:0]      ofs;
  logic                    unused_cfg;

  assign unused_cfg = ^{cfg_wdata[31:ADDR_W], cfg_wdata[WIN_LG2-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      win_en <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel) win_en <= cfg_wdata[0];
      else         base_q <= cfg_wdata[ADDR_W-1:WIN_LG2];
    end
  end

  assign hit = win_en && (bus_addr[ADDR_W-1:WIN_LG2] == base_q);
  assign ofs = bus_addr[WIN_LG2-1:0];

  always_comb begin
    case (int'(ofs))
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_ENABLE:  sel = SEL_ENABLE;
      OFS_CONTROL: sel = SEL_CONTROL;
      OFS_TMR_LO:  sel = SEL_TMR_LO;
      OFS_TMR_HI:  sel = SEL_TMR_HI;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pm_evt_regs.sv
`timescale 1ns/1ps
module pm_evt_regs import pm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_status,
  input  logic             wr_enable,
  input  logic             wr_control,
  input  logic [REG_W-1:0] wdata,
  input  logic             ev_rtc,
  input  logic             ev_pwrbtn,
  input  logic             ev_glock,
  input  logic             tmr_flip,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] enable,
  output logic [REG_W-1:0] control
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] status_d;
  logic             tmr_armed;

  // the timer event only counts while enabled and not already pending
  assign tmr_armed = enable[BIT_TMR] & ~status[BIT_TMR];

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_RTC] = ev_rtc;
    set_vec[BIT_PWR] = ev_pwrbtn;
    set_vec[BIT_GLK] = ev_glock;
    set_vec[BIT_TMR] = tmr_flip & tmr_armed;
  end

  assign clr_vec  = wr_status ? wdata : '0;
  // set wins over a same-cycle clear; unimplemented positions stay zero
  assign status_d = ((status & ~clr_vec) | set_vec) & EVT_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      enable  <= '0;
      control <= '0;
    end else begin
      status <= status_d;
      if (wr_enable)  enable  <= wdata;
      if (wr_control) control <= wdata;
    end
  end
endmodule

// File: rtl/pm_irq.sv
`timescale 1ns/1ps
module pm_irq import pm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] status,
  input  logic [REG_W-1:0] enable,
  output logic             sci
);
  always_ff @(posedge clk) begin
    if (!rst_n) sci <= 1'b0;
    else        sci <= |(status & enable & EVT_MASK);
  end
endmodule

// File: rtl/pm_event_ctrl.sv
`timescale 1ns/1ps
module pm_event_ctrl import pm_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              tmr_tick,
  input  logic              ev_pwrbtn,
  input  logic              ev_rtc,
  input  logic              ev_glock,
  output logic              sci_out
);
  localparam int WIN_LG2 = 6;

  logic             win_en;
  logic             hit;
  reg_sel_e         sel;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [REG_W-1:0] evt_status;
  logic [REG_W-1:0] evt_enable;
  logic [REG_W-1:0] evt_control;
  logic [31:0]      cnt_ext;
  logic [15:0]      rd_mux;
  logic             wr_hit;

  pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
    .win_en(win_en), .hit(hit), .sel(sel)
  );

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick),
    .count(tmr_cnt), .msb_flip(tmr_flip)
  );

  assign wr_hit = bus_wr & hit;

  pm_evt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_status(wr_hit && sel == SEL_STATUS),
    .wr_enable(wr_hit && sel == SEL_ENABLE),
    .wr_control(wr_hit && sel == SEL_CONTROL),
    .wdata(bus_wdata),
    .ev_rtc(ev_rtc), .ev_pwrbtn(ev_pwrbtn), .ev_glock(ev_glock),
    .tmr_flip(tmr_flip),
    .status(evt_status), .enable(evt_enable), .control(evt_control)
  );

  pm_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .status(evt_status), .enable(evt_enable), .sci(sci_out)
  );

  always_comb begin
    cnt_ext = '0;
    cnt_ext[TMR_W-1:0] = tmr_cnt;
    case (sel)
      SEL_STATUS:  rd_mux = evt_status;
      SEL_ENABLE:  rd_mux = evt_enable;
      SEL_CONTROL: rd_mux = evt_control;
      SEL_TMR_LO:  rd_mux = cnt_ext[15:0];
      SEL_TMR_HI:  rd_mux = cnt_ext[31:16];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= hit ? rd_mux : '0;
  end
endmodule

// File: rtl/pm_event_ctrl_chk.sv
`timescale 1ns/1ps
module pm_event_ctrl_chk import pm_pkg::*; #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sci_out,
  input logic [REG_W-1:0] status,
  input logic [REG_W-1:0] enable,
  input logic [TMR_W-1:0] tmr,
  input logic             tmr_tick,
  input logic             ev_pwrbtn,
  input logic             win_en
);
  // R9
  sci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_out == $past(|(status & enable & EVT_MASK)));

  // R4
  no_stray_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~EVT_MASK) == '0);

  // R4
  pwrbtn_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwrbtn |=> status[BIT_PWR]);

  // R8
  tmr_status_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[BIT_TMR]) |-> $past(enable[BIT_TMR]));

  // R7
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |=> tmr == TMR_W'($past(tmr) + 1'b1));

  // R2
  closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> $stable(enable));
endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sci_out(sci_out), .status(evt_status),
  .enable(evt_enable), .tmr(tmr_cnt), .tmr_tick(tmr_tick),
  .ev_pwrbtn(ev_pwrbtn), .win_en(win_en)
);

// File: tb/tb_pm_event_ctrl.sv
`timescale 1ns/1ps
module tb_pm_event_ctrl;
  localparam int TW = 8;
  localparam logic [15:0] MASK = 16'h0521;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        tmr_tick, ev_pwrbtn, ev_rtc, ev_glock, sci_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pm_event_ctrl #(.ADDR_W(16), .TMR_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_tick(tmr_tick), .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc),
    .ev_glock(ev_glock), .sci_out(sci_out)
  );

  // ---------------- reference model from the requirements ----------------
  logic [15:0]   m_st, m_en, m_ctl, m_rdata;
  logic [TW-1:0] m_tmr;
  logic [31:0]   m_base;
  logic          m_wen, m_sci, m_rd_done;

  function automatic logic [15:0] m_read(input logic [5:0] off);
    case (off)
      6'h00:   return m_st;
      6'h02:   return m_en;
      6'h04:   return m_ctl;
      6'h08:   return 16'(m_tmr);
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic        hit, ovf;
    logic [5:0]  off;
    logic [15:0] setv, clrv;
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_ctl <= '0; m_rdata <= '0; m_tmr <= '0;
      m_base <= '0; m_wen <= 1'b0; m_sci <= 1'b0; m_rd_done <= 1'b0;
    end else begin
      hit  = m_wen && (bus_addr[15:6] == m_base[15:6]);
      off  = bus_addr[5:0];
      ovf  = tmr_tick && (m_tmr[TW-2:0] == '1);
      setv = '0;
      setv[10] = ev_rtc;
      setv[8]  = ev_pwrbtn;
      setv[5]  = ev_glock;
      setv[0]  = ovf && m_en[0] && !m_st[0];
      clrv = (bus_wr && hit && off == 6'h00) ? (bus_wdata & MASK) : 16'h0;
      m_sci     <= |(m_st & m_en & MASK);
      m_rd_done <= bus_rd;
      if (bus_rd) m_rdata <= hit ? m_read(off) : 16'h0;
      m_st <= (m_st & ~clrv) | setv;
      if (bus_wr && hit && off == 6'h02) m_en  <= bus_wdata;
      if (bus_wr && hit && off == 6'h04) m_ctl <= bus_wdata;
      if (tmr_tick) m_tmr <= m_tmr + 1'b1;
      if (cfg_wr) begin
        if (cfg_sel) m_wen  <= cfg_wdata[0];
        else         m_base <= cfg_wdata & 32'h0000FFC0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 sci level", 32'(sci_out), 32'(m_sci));
      if (m_rd_done) chk("R3 read data", 32'(bus_rdata), 32'(m_rdata));
    end
  end

  // ---------------- stimulus helpers (start and end at a negedge) ----------------
  task automatic bwr(input logic [15:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [15:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d;
    brd(a, d);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic cfg(input logic s, input logic [31:0] v);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tmr_tick = 1'b1;
    repeat (n) @(negedge clk);
    tmr_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tmr_tick = 0; ev_pwrbtn = 0; ev_rtc = 0; ev_glock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sci after reset", 32'(sci_out), 0);
    chk("R1 rdata after reset", 32'(bus_rdata), 0);
    rdchk("R2 closed window reads zero", 16'h0000, 16'h0000);

    // R2 placement, closed-window write ignored
    cfg(1'b0, 32'h1234ABCD);
    bwr(16'hABC2, 16'hFFFF);
    cfg(1'b1, 32'h00000001);
    rdchk("R2 write while closed ignored", 16'hABC2, 16'h0000);
    rdchk("R1 status zero", 16'hABC0, 16'h0000);
    rdchk("R1 control zero", 16'hABC4, 16'h0000);
    rdchk("R1 timer zero", 16'hABC8, 16'h0000);

    // R6 control read/write, R3 unused offsets, R2 outside window
    bwr(16'hABC4, 16'hBEEF);
    rdchk("R6 control readback", 16'hABC4, 16'hBEEF);
    bwr(16'hABCC, 16'h1234);
    rdchk("R3 unused offset reads zero", 16'hABCC, 16'h0000);
    rdchk("R3 odd offset reads zero", 16'hABC5, 16'h0000);
    rdchk("R2 outside window reads zero", 16'hAC04, 16'h0000);
    bwr(16'hAC04, 16'h0F0F);
    rdchk("R2 outside write ignored", 16'hABC4, 16'hBEEF);

    // R4 events latch regardless of enable
    ev_pwrbtn = 1'b1; @(negedge clk); ev_pwrbtn = 1'b0;
    rdchk("R4 pwrbtn status", 16'hABC0, 16'h0100);
    chk("R9 no irq with enable clear", 32'(sci_out), 0);
    ev_rtc = 1'b1; ev_glock = 1'b1; @(negedge clk); ev_rtc = 1'b0; ev_glock = 1'b0;
    rdchk("R4 rtc and glock status", 16'hABC0, 16'h0520);

    // R5 write-one-to-clear, set wins
    bwr(16'hABC0, 16'h0020);
    rdchk("R5 clear glock", 16'hABC0, 16'h0500);
    bwr(16'hABC0, 16'h0000);
    rdchk("R5 zero write keeps", 16'hABC0, 16'h0500);
    ev_rtc = 1'b1; bwr(16'hABC0, 16'h0400); ev_rtc = 1'b0;
    rdchk("R5 set wins over clear", 16'hABC0, 16'h0500);
    bwr(16'hABC0, 16'hFFFF);
    rdchk("R5 clear all", 16'hABC0, 16'h0000);

    // R9 latency and enable gating
    bwr(16'hABC2, 16'h0100);
    rdchk("R6 enable readback", 16'hABC2, 16'h0100);
    ev_pwrbtn = 1'b1; @(negedge clk); ev_pwrbtn = 1'b0;
    chk("R9 irq one clock after status", 32'(sci_out), 0);
    @(negedge clk);
    chk("R9 irq asserted", 32'(sci_out), 1);
    bwr(16'hABC0, 16'h0100);
    @(negedge clk);
    chk("R9 irq drops after clear", 32'(sci_out), 0);
    bwr(16'hABC2, 16'hFADE);
    ev_glock = 1'b1; @(negedge clk); ev_glock = 1'b0;
    @(negedge clk);
    chk("R9 glock disabled no irq", 32'(sci_out), 0);
    bwr(16'hABC0, 16'hFFFF);

    // R2 closing the window
    cfg(1'b1, 32'h000000FE);
    bwr(16'hABC2, 16'h0000);
    cfg(1'b1, 32'h00000001);
    rdchk("R2 closed-window write ignored", 16'hABC2, 16'hFADE);

    // R8 disarmed flip, then armed flip at wrap, R7 counting
    bwr(16'hABC2, 16'h0000);
    ticks(128);
    rdchk("R7 timer count 128", 16'hABC8, 16'h0080);
    rdchk("R8 flip ignored while disabled", 16'hABC0, 16'h0000);
    bwr(16'hABC2, 16'h0001);
    ticks(127);
    rdchk("R8 no status before flip", 16'hABC0, 16'h0000);
    ticks(1);
    rdchk("R7 timer wrapped", 16'hABC8, 16'h0000);
    rdchk("R8 status on armed flip", 16'hABC0, 16'h0001);
    chk("R9 timer irq", 32'(sci_out), 1);
    rdchk("R3 timer high half zero-extended", 16'hABCA, 16'h0000);
    bwr(16'hABC0, 16'h0001);

    // constrained random phase, checked against the model
    for (int i = 0; i < 4000; i++) begin
      bus_wr = ($urandom % 4) == 0;
      bus_rd = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) bus_addr = 16'($urandom);
      else if (($urandom % 16) == 0) bus_addr = {m_base[15:6], 6'($urandom % 64)};
      else bus_addr = {m_base[15:6], 6'(($urandom % 7) * 2)};
      bus_wdata = 16'($urandom);
      ev_pwrbtn = ($urandom % 20) == 0;
      ev_rtc    = ($urandom % 20) == 0;
      ev_glock  = ($urandom % 20) == 0;
      tmr_tick  = ($urandom % 2) == 0;
      cfg_wr    = ($urandom % 150) == 0;
      cfg_sel   = ($urandom % 2) == 0;
      if (cfg_sel) cfg_wdata = 32'((($urandom % 4) != 0) ? 1 : 0);
      else cfg_wdata = (($urandom % 2) == 0) ? 32'h0000ABC0 : $urandom;
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; tmr_tick = 0; cfg_wr = 0;
    ev_pwrbtn = 0; ev_rtc = 0; ev_glock = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule